// File: doc/BRIEF.md
# Pipelined Reciprocal-Table Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width without any shift-and-subtract iteration. The divisor addresses a synchronous table of scaled reciprocals. The dividend is multiplied by the selected reciprocal, and the upper product bits form a provisional quotient. A second multiply (divisor times provisional quotient), a subtraction and a one-step fix-up then give the exact floor quotient and the matching remainder.

The table contents are computed at elaboration from the width parameters, so no initialisation file is needed. The pipeline has three stages (table read, quotient multiply, remainder multiply with correction). It accepts a new operand pair on every clock, and each result appears exactly three clocks after its operands. A zero divisor gives a defined result and raises a flag that travels with that result.

Top module: `recip_divider`

## Requirements
- R1: For a non-zero divisor, `res_quot` equals floor(dividend / divisor) and `res_rem` equals dividend mod divisor, for every pair of W-bit unsigned operands.
- R2: Every valid result with a non-zero divisor satisfies dividend = divisor * quotient + remainder with remainder < divisor.
- R3: `res_valid` is high at a clock edge exactly when `op_valid` was high three rising edges earlier, provided reset was not asserted in that window.
- R4: Operands presented on consecutive clocks, with or without idle cycles between them, each give their own result, in order, one per clock.
- R5: A divisor of 0 gives `res_quot` all ones (8'hFF at W = 8), `res_rem` equal to the dividend, and `res_dz` = 1. `res_dz` is 0 for every non-zero divisor.
- R6: A rising clock edge with `rst_n` low clears every pipeline valid bit. `res_valid` stays low for the next three edges, and operands offered while `rst_n` is low produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| op_valid | input | 1 | Operand pair present this cycle |
| op_dividend | input | W | Unsigned dividend |
| op_divisor | input | W | Unsigned divisor, also the table address |
| res_valid | output | 1 | Result present this cycle |
| res_quot | output | W | Floor quotient, all ones on divide by zero |
| res_rem | output | W | Remainder, the dividend on divide by zero |
| res_dz | output | 1 | Divisor of this result was zero |

## Verification
The bench builds the block at its default size, W = 8 with a 16-bit reciprocal scale. At that size the complete operand space of 65,536 pairs can be streamed back to back, so every table entry, including the zero-divisor and divisor-one ends, is checked against arithmetic division with every dividend. Idle cycles placed at irregular points in the stream, together with a reset pulse applied while operations are in flight, exercise the three-cycle valid alignment and the pipeline flush.

// File: rtl/rdiv_pkg.sv
// Package: shared helpers for the reciprocal-table divider.
// Assumes the scale exponent stays at or below 30 so that the arithmetic fits in 64 bits.
package rdiv_pkg;

    // Scaled reciprocal, ceil(2^k / d). An entry for d = 0 is never used and returns 0.
    function automatic longint unsigned recip_entry(input longint unsigned d,
                                                    input int unsigned k);
        longint unsigned scale;
        scale = longint'(1) << k;
        if (d == 0)
            return 0;
        return (scale + d - 1) / d;
    endfunction

endpackage

// File: rtl/rdiv_recip_rom.sv
// Module: synchronous reciprocal table addressed by the divisor.
// Assumes 2^W entries of K+1 bits. The contents are computed at elaboration
// and one clock of read latency is taken.
module rdiv_recip_rom #(
    parameter int W = 8,
    parameter int K = 2 * W
) (
    input  logic         clk,
    input  logic [W-1:0] rd_addr,
    output logic [K:0]   rd_data
);
    import rdiv_pkg::*;

    localparam int DEPTH = 1 << W;
    localparam int RW    = K + 1;

    logic [RW-1:0] table_q [DEPTH];

    // One constant entry per divisor value.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        assign table_q[gi] = RW'(recip_entry(longint'(gi), K));
    end

    // Registered read of the addressed entry.
    always_ff @(posedge clk) begin
        rd_data <= table_q[rd_addr];
    end
endmodule

// File: rtl/rdiv_quot_stage.sv
// Module: second pipeline stage. Multiplies the dividend by the reciprocal and keeps
// the bits above the scale point as a provisional quotient, which may be one too high.
// Assumes its inputs are aligned with the table output.
module rdiv_quot_stage #(
    parameter int W = 8,
    parameter int K = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [K:0]   in_recip,
    output logic         out_vld,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic [W:0]   out_qraw
);
    localparam int PW = W + K + 1;

    logic [W:0] qraw_next;

    // Product of the dividend and the reciprocal, shifted down by the scale.
    always_comb begin
        qraw_next = (W+1)'((PW'(in_a) * PW'(in_recip)) >> K);
    end

    // Valid bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    // Data registers, not reset.
    always_ff @(posedge clk) begin
        out_a    <= in_a;
        out_b    <= in_b;
        out_qraw <= qraw_next;
    end
endmodule

// File: rtl/rdiv_fix_stage.sv
// Module: final stage. Forms the remainder as dividend - divisor*quotient, corrects the
// provisional quotient by one step in either direction, and handles a zero divisor.
// Assumes the provisional quotient is within one of the exact floor quotient.
module rdiv_fix_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W:0]   in_qraw,
    output logic         out_vld,
    output logic [W-1:0] out_q,
    output logic [W-1:0] out_r,
    output logic         out_dz
);
    localparam int DW = 2 * W + 2;

    logic [DW-1:0] prod;
    logic [DW-1:0] diff;
    logic [DW-1:0] b_ext;
    logic          diff_neg;
    logic [W-1:0]  q_next;
    logic [W-1:0]  r_next;
    logic          dz_next;

    // Remainder check, then correction of the provisional quotient.
    always_comb begin
        b_ext    = DW'(in_b);
        prod     = b_ext * DW'(in_qraw);
        diff     = DW'(in_a) - prod;
        diff_neg = diff[DW-1];
        dz_next  = (in_b == '0);
        if (dz_next) begin
            q_next = '1;
            r_next = in_a;
        end else if (diff_neg) begin
            q_next = W'(in_qraw - 1'b1);
            r_next = W'(diff + b_ext);
        end else if (diff >= b_ext) begin
            q_next = W'(in_qraw + 1'b1);
            r_next = W'(diff - b_ext);
        end else begin
            q_next = W'(in_qraw);
            r_next = W'(diff);
        end
    end

    // Valid bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    // Result registers, not reset.
    always_ff @(posedge clk) begin
        out_q  <= q_next;
        out_r  <= r_next;
        out_dz <= dz_next;
    end
endmodule

// File: rtl/recip_divider.sv
// Module: top of the three-stage reciprocal-table divider.
// Stage 1 reads the table and registers the operands. Stage 2 forms the provisional
// quotient. Stage 3 forms the remainder and corrects the quotient. Assumes W <= 15.
module recip_divider #(
    parameter int W = 8,
    parameter int K = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [W-1:0] op_dividend,
    input  logic [W-1:0] op_divisor,
    output logic         res_valid,
    output logic [W-1:0] res_quot,
    output logic [W-1:0] res_rem,
    output logic         res_dz
);
    logic         s1_vld;
    logic [W-1:0] s1_a;
    logic [W-1:0] s1_b;
    logic [K:0]   s1_recip;
    logic         s2_vld;
    logic [W-1:0] s2_a;
    logic [W-1:0] s2_b;
    logic [W:0]   s2_qraw;

    // Stage 1 valid, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_vld <= 1'b0;
        else        s1_vld <= op_valid;
    end

    // Stage 1 operand registers, aligned with the table read.
    always_ff @(posedge clk) begin
        s1_a <= op_dividend;
        s1_b <= op_divisor;
    end

    rdiv_recip_rom #(.W(W), .K(K)) rom_i (
        .clk     (clk),
        .rd_addr (op_divisor),
        .rd_data (s1_recip)
    );

    rdiv_quot_stage #(.W(W), .K(K)) quot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (s1_vld),
        .in_a     (s1_a),
        .in_b     (s1_b),
        .in_recip (s1_recip),
        .out_vld  (s2_vld),
        .out_a    (s2_a),
        .out_b    (s2_b),
        .out_qraw (s2_qraw)
    );

    rdiv_fix_stage #(.W(W)) fix_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s2_vld),
        .in_a    (s2_a),
        .in_b    (s2_b),
        .in_qraw (s2_qraw),
        .out_vld (res_valid),
        .out_q   (res_quot),
        .out_r   (res_rem),
        .out_dz  (res_dz)
    );
endmodule

// File: rtl/rdiv_checker.sv
// Module: property checker for recip_divider. It keeps its own three-deep record of the
// operands seen at the ports and compares each result with it.
module rdiv_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [W-1:0] op_dividend,
    input logic [W-1:0] op_divisor,
    input logic         res_valid,
    input logic [W-1:0] res_quot,
    input logic [W-1:0] res_rem,
    input logic         res_dz
);
    localparam int EW = 2 * W;

    logic [1:0]   since_rst;
    logic [2:0]   v_hist;
    logic [W-1:0] a_hist [3];
    logic [W-1:0] b_hist [3];

    // Edges elapsed since the last reset edge, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // Record of the operands offered at the last three edges.
    always_ff @(posedge clk) begin
        v_hist    <= {v_hist[1:0], op_valid & rst_n};
        a_hist[0] <= op_dividend;
        b_hist[0] <= op_divisor;
        a_hist[1] <= a_hist[0];
        b_hist[1] <= b_hist[0];
        a_hist[2] <= a_hist[1];
        b_hist[2] <= b_hist[1];
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (res_valid == v_hist[2]));

    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> !res_valid);

    a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && b_hist[2] != '0) |->
        (EW'(res_quot) * EW'(b_hist[2]) + EW'(res_rem) == EW'(a_hist[2])
         && res_rem < b_hist[2]));

    a_r5_dz_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_dz == (b_hist[2] == '0)));

    a_r5_dz_values: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dz) |-> (res_quot == '1 && res_rem == a_hist[2]));
endmodule

bind recip_divider rdiv_checker #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_dividend (op_dividend),
    .op_divisor  (op_divisor),
    .res_valid   (res_valid),
    .res_quot    (res_quot),
    .res_rem     (res_rem),
    .res_dz      (res_dz)
);

// File: tb/recip_divider_tb_top.sv
`timescale 1ns/1ps
// Bench: streams every operand pair through the divider, with occasional idle cycles
// and one reset pulse while operations are in flight.
module recip_divider_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [W-1:0] op_dividend = '0;
    logic [W-1:0] op_divisor = '0;
    logic         res_valid;
    logic [W-1:0] res_quot;
    logic [W-1:0] res_rem;
    logic         res_dz;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Operands driven at the last three falling edges, newest first.
    logic         hv [3] = '{1'b0, 1'b0, 1'b0};
    logic [W-1:0] ha [3];
    logic [W-1:0] hb [3];

    always #4 clk = ~clk;

    recip_divider #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_dividend(op_dividend), .op_divisor(op_divisor),
        .res_valid(res_valid), .res_quot(res_quot), .res_rem(res_rem), .res_dz(res_dz)
    );

    task automatic fail_line(input string req, input int act, input int exp);
        n_fail++;
        $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    endtask

    // Compare the outputs with the entry driven three falling edges earlier.
    task automatic check_out();
        int eq, er;
        n_tests++;
        if (res_valid !== hv[2]) fail_line("R3/R4 valid", int'(res_valid), int'(hv[2]));
        if (hv[2] === 1'b1) begin
            if (hb[2] == 0) begin
                eq = (1 << W) - 1;
                er = ha[2];
                n_tests++;
                if (res_dz !== 1'b1) fail_line("R5 dz flag", int'(res_dz), 1);
                if (res_quot !== W'(eq)) fail_line("R5 quotient", int'(res_quot), eq);
                if (res_rem !== W'(er)) fail_line("R5 remainder", int'(res_rem), er);
            end else begin
                eq = int'(ha[2]) / int'(hb[2]);
                er = int'(ha[2]) % int'(hb[2]);
                n_tests++;
                if (res_dz !== 1'b0) fail_line("R5 dz clear", int'(res_dz), 0);
                if (res_quot !== W'(eq)) fail_line("R1 quotient", int'(res_quot), eq);
                if (res_rem !== W'(er)) fail_line("R1/R2 remainder", int'(res_rem), er);
            end
        end
    endtask

    // One falling edge: check, then drive the next operands (accepted only if rst_n is high).
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic rn);
        @(negedge clk);
        check_out();
        rst_n       = rn;
        op_valid    = v;
        op_dividend = a;
        op_divisor  = b;
        hv[2] = hv[1]; ha[2] = ha[1]; hb[2] = hb[1];
        hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0];
        hv[0] = v & rn; ha[0] = a; hb[0] = b;
        if (!rn) begin
            hv[1] = 1'b0;
            hv[2] = 1'b0;
        end
    endtask

    initial begin : stim
        // Reset held for a few edges, then reset state checked (R6).
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (res_valid !== 1'b0) fail_line("R6 reset state", int'(res_valid), 0);
        rst_n = 1'b1;
        // Full sweep with irregular bubbles (R1, R2, R3, R4, R5).
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                if (((a * 256 + b) % 97) == 5) step(1'b0, W'(b), W'(a), 1'b1);
                step(1'b1, W'(a), W'(b), 1'b1);
            end
        end
        // Reset pulse with operations in flight (R6).
        step(1'b1, 8'd200, 8'd7, 1'b1);
        step(1'b1, 8'd9, 8'd0, 1'b1);
        step(1'b1, 8'd100, 8'd3, 1'b0);
        step(1'b1, 8'd55, 8'd5, 1'b1);
        step(1'b1, 8'd255, 8'd1, 1'b1);
        step(1'b1, 8'd1, 8'd255, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, '0, '0, 1'b1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule